// File: doc/BRIEF.md
# Peripheral Window Decoder with Acknowledge

This block decodes the address of an asynchronous 68000-style bus into one active-low select per peripheral sub-window in the region 0xA00000 to 0xA1FFFF. It also produces an active-low transfer acknowledge. The acknowledge is driven only for addresses that have a device behind them, so a master that strays into an unmapped hole gets no acknowledge and stalls. One window hands its acknowledge to an external device, so it gets a select but no acknowledge from this block. Every peripheral is treated as always ready: for a mapped window, the acknowledge follows the strobes with no wait states.

The block also holds a one-bit control register for the low ROM space. While the bit is clear, bus cycles below 0x400000 select the boot ROM. While it is set, they select the cartridge ROM and the boot ROM is unmapped. All outputs are registered. Each one shows the decode of the inputs sampled at the previous rising clock edge.

Top module: `periph_decode`

## Requirements
- R1: A cycle at 0xA00000–0xA0FFFF drives selN[0] low and, once a data strobe is low, drives dtackN low.
- R2: For k = 0..4, a cycle at 0xA1k000–0xA1k0FF drives selN[k+1] low and, once a data strobe is low, drives dtackN low.
- R3: A cycle at 0xA15000–0xA150FF drives selN[6] low and never drives dtackN low.
- R4: Every other address in 0xA00000–0xA1FFFF that is not the control register, and every address at or above 0x400000 outside the windows, leaves all of selN and dtackN high.
- R5: The control register sits at 0xA14100/0xA14101 (A0 ignored) and is acknowledged like a mapped window. A cycle there with rwN low and udsN low loads wdata[8] into the register. Reads, and writes with only ldsN low, leave it unchanged.
- R6: While rstN is low, every output is high and the register clears to 0. After reset, ROM cycles select the boot ROM.
- R7: A cycle below 0x400000 drives bootRomSelN low when the register is 0 and cartRomSelN low when it is 1. That cycle gives no dtackN from this block, and the two ROM selects are never low together.
- R8: Selects need only asN low. dtackN also needs udsN or ldsN low.
- R9: Outputs change one clock edge after the inputs are sampled. On the edge that samples asN high, every output returns high.
- R10: At most one bit of selN is low at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| addr | input | 24 | Byte address (A0 included) |
| asN | input | 1 | Address strobe, active low |
| rwN | input | 1 | High for read, low for write |
| udsN | input | 1 | Upper data strobe, active low |
| ldsN | input | 1 | Lower data strobe, active low |
| wdata | input | 16 | Write data bus |
| selN | output | 7 | Window selects, active low, bit order as in R1–R3 |
| dtackN | output | 1 | Transfer acknowledge, active low |
| bootRomSelN | output | 1 | Boot ROM select, active low |
| cartRomSelN | output | 1 | Cartridge ROM select, active low |

## Verification
On every cycle, the embedded assertions check the following: at most one select is low, the two ROM selects never overlap, the external-acknowledge window never gets an acknowledge, everything releases on the edge after the strobe rises, and the register changes only on a qualified write. Only the bench scenarios can show that each address lands in the right window. These are the sweep across the whole peripheral region, the strobe-less passes and the register write sequences, and they also show that holes stay unacknowledged and that the ROM steering follows the register.

// File: rtl/pwd_pkg.sv
package pwd_pkg;
  localparam int NUM_WIN = 7;

  typedef struct packed {
    logic [NUM_WIN-1:0] winHit;
    logic               ackHit;
    logic               romHit;
    logic               regWr;
    logic               cycleAct;
    logic               dataAct;
  } decStrb_t;
endpackage

// File: rtl/pwd_ctrl.sv
module pwd_ctrl
  import pwd_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter logic [7:0] PAGE_MEM = 8'hA0,
  parameter logic [7:0] PAGE_IO = 8'hA1,
  parameter logic [NUM_WIN-1:0] ACK_MASK = 7'b0111111,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 24'hA14100,
  parameter logic [ADDR_W-1:0] ROM_TOP = 24'h400000
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              asN,
  input  logic              rwN,
  input  logic              udsN,
  input  logic              ldsN,
  output decStrb_t          strb
);
  logic [7:0] page;
  logic [3:0] blk;
  logic [3:0] sub;
  logic [NUM_WIN-1:0] winHit;
  logic regHit;

  assign page = addr[ADDR_W-1 -: 8];
  assign blk  = addr[ADDR_W-9 -: 4];
  assign sub  = addr[ADDR_W-13 -: 4];

  for (genvar i = 0; i < NUM_WIN; i++) begin : gWin
    if (i == 0) begin : gMem
      assign winHit[i] = (page == PAGE_MEM);
    end else begin : gIo
      assign winHit[i] = (page == PAGE_IO) && (blk == 4'(i-1)) && (sub == 4'h0);
    end
  end

  assign regHit = (addr[ADDR_W-1:1] == CTRL_ADDR[ADDR_W-1:1]);

  always_comb begin
    strb.winHit   = winHit;
    strb.ackHit   = (|(winHit & ACK_MASK)) || regHit;
    strb.romHit   = (addr < ROM_TOP);
    strb.cycleAct = !asN;
    strb.dataAct  = !asN && (!udsN || !ldsN);
    strb.regWr    = !asN && !rwN && !udsN && regHit;
  end
endmodule

// File: rtl/pwd_datapath.sv
module pwd_datapath
  import pwd_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  decStrb_t           strb,
  input  logic               wrBit,
  output logic [NUM_WIN-1:0] selN,
  output logic               dtackN,
  output logic               bootRomSelN,
  output logic               cartRomSelN
);
  logic cartEn;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      selN        <= '1;
      dtackN      <= 1'b1;
      bootRomSelN <= 1'b1;
      cartRomSelN <= 1'b1;
      cartEn      <= 1'b0;
    end else begin
      selN        <= ~(strb.winHit & {NUM_WIN{strb.cycleAct}});
      dtackN      <= !(strb.dataAct && strb.ackHit);
      bootRomSelN <= !(strb.cycleAct && strb.romHit && !cartEn);
      cartRomSelN <= !(strb.cycleAct && strb.romHit && cartEn);
      if (strb.regWr) cartEn <= wrBit;
    end
  end

  assert_single_sel_R10: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(~selN));

  assert_rom_excl_R7: assert property (@(posedge clk) disable iff (!rstN)
    !(!bootRomSelN && !cartRomSelN));

  assert_ext_no_ack_R3: assert property (@(posedge clk) disable iff (!rstN)
    !selN[NUM_WIN-1] |-> dtackN);

  assert_release_R9: assert property (@(posedge clk) disable iff (!rstN)
    !strb.cycleAct |=> (dtackN && (&selN) && bootRomSelN && cartRomSelN));

  assert_reg_hold_R5: assert property (@(posedge clk) disable iff (!rstN)
    !strb.regWr |=> $stable(cartEn));
endmodule

// File: rtl/periph_decode.sv
module periph_decode
  import pwd_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int DATA_W = 16,
  parameter int CART_BIT = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [ADDR_W-1:0]  addr,
  input  logic               asN,
  input  logic               rwN,
  input  logic               udsN,
  input  logic               ldsN,
  input  logic [DATA_W-1:0]  wdata,
  output logic [NUM_WIN-1:0] selN,
  output logic               dtackN,
  output logic               bootRomSelN,
  output logic               cartRomSelN
);
  localparam logic [DATA_W-1:0] KEEP_MASK = DATA_W'(1) << CART_BIT;

  decStrb_t strb;
  logic unusedData;

  assign unusedData = ^(wdata & ~KEEP_MASK);

  pwd_ctrl #(.ADDR_W(ADDR_W)) uCtrl (
    .addr(addr), .asN(asN), .rwN(rwN), .udsN(udsN), .ldsN(ldsN), .strb(strb)
  );

  pwd_datapath uData (
    .clk(clk), .rstN(rstN), .strb(strb), .wrBit(wdata[CART_BIT]),
    .selN(selN), .dtackN(dtackN),
    .bootRomSelN(bootRomSelN), .cartRomSelN(cartRomSelN)
  );
endmodule

// File: tb/periph_decode_test.sv
module periph_decode_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [23:0] addr = '0;
  logic        asN = 1'b1;
  logic        rwN = 1'b1;
  logic        udsN = 1'b1;
  logic        ldsN = 1'b1;
  logic [15:0] wdata = '0;
  logic [6:0]  selN;
  logic        dtackN;
  logic        bootRomSelN;
  logic        cartRomSelN;

  int  nChecks = 0;
  int  nFail = 0;
  bit  done = 1'b0;
  bit  cartModel = 1'b0;

  periph_decode uut (
    .clk(clk), .rstN(rstN), .addr(addr), .asN(asN), .rwN(rwN),
    .udsN(udsN), .ldsN(ldsN), .wdata(wdata), .selN(selN), .dtackN(dtackN),
    .bootRomSelN(bootRomSelN), .cartRomSelN(cartRomSelN)
  );

  always #4 clk = ~clk;

  function automatic logic [6:0] expSel(input logic [23:0] a);
    logic [6:0] v = '0;
    v[0] = (a >= 24'hA00000) && (a <= 24'hA0FFFF);
    for (int k = 1; k < 7; k++) begin
      int base = 'hA10000 + (k - 1) * 'h1000;
      v[k] = (int'(a) >= base) && (int'(a) <= base + 'hFF);
    end
    return v;
  endfunction

  function automatic bit isReg(input logic [23:0] a);
    return (a == 24'hA14100) || (a == 24'hA14101);
  endfunction

  task automatic check(input string tag, input logic [10:0] act, input logic [10:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s addr=%h actual=%b expected=%b", tag, addr, act, exp);
    end
  endtask

  task automatic busCycle(input logic [23:0] a, input bit wr, input bit u, input bit l,
                          input logic [15:0] d);
    logic [6:0] s;
    bit ack, boot, cart, strobe;
    string tag;
    @(negedge clk);
    addr = a; asN = 1'b0; rwN = !wr; udsN = !u; ldsN = !l; wdata = d;
    s = expSel(a);
    strobe = u || l;
    ack = strobe && (((s & 7'h3F) != 0) || isReg(a));
    boot = (a < 24'h400000) && !cartModel;
    cart = (a < 24'h400000) && cartModel;
    if (a < 24'h400000) tag = "R7";
    else if (isReg(a)) tag = "R5";
    else if (!strobe) tag = "R8";
    else if (s[6]) tag = "R3";
    else if (s[0]) tag = "R1";
    else if (s != 0) tag = "R2";
    else tag = "R4";
    @(posedge clk);
    @(negedge clk);
    check(tag, {selN, dtackN, bootRomSelN, cartRomSelN, 1'b0},
          {~s, !ack, !boot, !cart, 1'b0});
    check("R10", {10'd0, $countones(~selN) <= 1}, 11'd1);
    if (wr && u && isReg(a)) cartModel = d[8];
    asN = 1'b1; udsN = 1'b1; ldsN = 1'b1; rwN = 1'b1;
    @(posedge clk);
    @(negedge clk);
    check("R9", {selN, dtackN, bootRomSelN, cartRomSelN, 1'b0}, 11'h7FE);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R6", {selN, dtackN, bootRomSelN, cartRomSelN, 1'b0}, 11'h7FE);
    rstN = 1'b1;
    busCycle(24'h001000, 0, 1, 1, 16'h0);                 // R6 boot after reset
    for (int hi = 0; hi < 2; hi++)
      for (int mid = 0; mid < 256; mid++)
        for (int lo = 0; lo < 3; lo++)
          busCycle(24'hA00000 | (hi << 16) | (mid << 8) | (lo * 'h7F), 0, 1, 0, 16'h0);
    for (int mid = 0; mid < 256; mid++)                    // R8 no data strobe
      busCycle(24'hA10000 | (mid << 8), 0, 0, 0, 16'h0);
    busCycle(24'hA000FF, 0, 0, 1, 16'h0);                  // R8 lower strobe only
    busCycle(24'h000000, 0, 1, 1, 16'h0);
    busCycle(24'h3FFFFE, 0, 1, 1, 16'h0);
    busCycle(24'h400000, 0, 1, 1, 16'h0);
    busCycle(24'h9FFFFF, 0, 1, 1, 16'h0);
    busCycle(24'hA20000, 0, 1, 1, 16'h0);
    busCycle(24'hC00000, 0, 1, 1, 16'h0);
    busCycle(24'hFFFFFF, 0, 1, 1, 16'h0);
    // R5 register sequences
    busCycle(24'hA14100, 1, 1, 1, 16'h0100);
    busCycle(24'h200000, 0, 1, 1, 16'h0);                  // R7 cartridge selected
    busCycle(24'hA14100, 1, 0, 1, 16'h0000);               // R5 lower-only write ignored
    busCycle(24'h000100, 0, 1, 1, 16'h0);
    busCycle(24'hA14100, 0, 1, 1, 16'h0000);               // R5 read ignored
    busCycle(24'h3FFFFF, 0, 1, 1, 16'h0);
    busCycle(24'hA14101, 1, 1, 0, 16'hFEFF);               // R5 odd address write clears
    busCycle(24'h000002, 0, 1, 1, 16'h0);
    busCycle(24'hA14102, 1, 1, 1, 16'h0100);               // R4 neighbour not a register
    busCycle(24'h000004, 0, 1, 1, 16'h0);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      nFail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
      $finish;
    end
  end
endmodule